// File: doc/BRIEF.md
# Serial Peripheral Port with Completion Flag

This block is a byte-wide SPI engine mapped onto a small register bus. Software programs a control register to pick master or slave operation, the bit order on the wire, the idle level of the serial clock and the edge on which data is captured. A write to the data register then moves one 8-bit word out on `sdo` while a word comes in on `sdi`. In master mode the block makes its own serial clock by dividing the system clock. In slave mode it follows `sclk_in` whenever `sel_n` is low.

Completion of a transfer raises a flag and, when enabled, an interrupt request. The flag is cleared either by an acknowledge pulse or by reading the status register while the flag is set and then accessing the data register. A write to the data register during a transfer is dropped and reported by a collision flag. If `sel_n` falls while the block is master, another master is assumed to own the bus. The block then drops to slave mode and raises the completion flag.

Top module: `spi_port`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00, and `irq` and `sclk_drive` are 0.
- R2: Control bit 2 sets the bit order. When it is 1 the least significant bit goes out first; when it is 0 the most significant bit goes out first.
- R3: Control bit 3 sets the idle level of `sclk_out` in master mode: high when 1, low when 0. The line is at that level before and after each transfer.
- R4: Control bit 4 selects the phase. When it is 0, data is captured on the leading serial-clock edge and changes on the trailing edge. When it is 1, data changes on the leading edge and is captured on the trailing edge. Each master transfer makes exactly 16 serial-clock edges.
- R5: In master mode, a transfer lasts 8×N system clock cycles from the edge that accepts the data write, and the completion flag (status bit 7) becomes 1 exactly then. N is selected by control bits 6:5 and status bit 0 (double speed): 4, 16, 64, 128 for 00, 01, 10, 11 at double speed 0, and 2, 8, 32, 64 at double speed 1.
- R6: With `sdo` looped to `sdi`, the data register (address 2) reads back the transmitted byte after completion, in every bit order and phase.
- R7: `irq` is 1 exactly when the completion flag, control bit 7 (interrupt enable) and the `irq_gate` input are all 1.
- R8: Reading status (address 1) while the completion flag is 1, followed by a read or write of the data register, clears the completion flag and the collision flag.
- R9: A one-cycle `irq_ack` pulse clears the completion flag on the next clock edge.
- R10: A write to the data register while a transfer is active sets the collision flag (status bit 6). The write is ignored, so the byte in flight and the received byte are unchanged.
- R11: When `sel_n` is low for two synchronizer stages while control bits 0 (enable) and 1 (master) are 1, the block clears control bit 1 on the following edge, sets the completion flag and releases `sclk_drive`. Control bit 1 stays 0 until software writes it again.
- R12: In the status register only bit 0 is writable; bits 5:1 always read 0.
- R13: In slave mode (control bit 0 = 1, bit 1 = 0) with `sel_n` low, the block shifts on `sclk_in` edges. It presents the byte loaded into the data register on `sdo`, captures `sdi`, and sets the completion flag after the 16th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_gate | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sel_n | input | 1 | Select input, active low |
| sclk_in | input | 1 | Serial clock from the bus in slave mode |
| sclk_out | output | 1 | Generated serial clock in master mode |
| sclk_drive | output | 1 | High when the block drives the serial clock |
| sdi | input | 1 | Serial data into the shift register |
| sdo | output | 1 | Serial data out of the shift register |

## Verification
The write that starts a master transfer is captured on one edge, and the completion flag appears exactly 8×N edges later. The bench therefore samples the status register one cycle before and on that edge for all eight ratios, which pins the divider exactly. A `sel_n` fall passes two synchronizer flops, so the master bit and `sclk_drive` change on the third edge after the pin moves, and the bench checks the second edge (no change) and the third edge (change). Flag clears by `irq_ack` or by the read sequence land on the edge that takes the strobe, and are sampled one time step after it. Wire bit order and phase are rebuilt from the value `sdo` held just before each serial-clock transition of the capture type.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // control register image, bit 7 down to bit 0
  typedef struct packed {
    logic       irq_en;
    logic [1:0] rate;
    logic       pha;
    logic       pol;
    logic       lsb;
    logic       master;
    logic       en;
  } ctrl_t;

  // half of the division ratio, minus one, for the serial clock counter
  function automatic logic [7:0] half_minus_one(input logic [1:0] rate, input logic dbl);
    logic [3:0] lg;
    lg = (rate == 2'd3) ? 4'd7 : ({1'b0, rate, 1'b0} + 4'd2);
    lg = lg - {3'b000, dbl};
    return (8'd1 << (lg - 4'd1)) - 8'd1;
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned           W       = 2,
  parameter logic [W-1:0]          RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= RST_VAL;
      st2_q <= RST_VAL;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = st2_q;

endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             tick,
  output logic             lvl
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run) begin
      cnt_d = half_m1;
      lvl_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d = half_m1;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // two ticks never come back to back unless the ratio is the fastest one
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (half_m1 != '0)) |=> !tick);

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         go,
  input  logic         abort,
  input  logic         edge_pulse,
  input  logic         lsb_first,
  input  logic         cpha,
  input  logic         sdi,
  input  logic [W-1:0] ldata,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] word
);

  localparam int unsigned      CNT_W = $clog2(2 * W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * W - 1);

  logic [W-1:0]     sr_q, sr_d;
  logic             rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             lead, last, sample_now, shift_now;

  function automatic logic [W-1:0] push(input logic [W-1:0] v, input logic b, input logic lsb);
    return lsb ? {b, v[W-1:1]} : {v[W-2:0], b};
  endfunction

  always_comb begin
    lead       = ~cnt_q[0];
    last       = (cnt_q == LAST);
    sample_now = edge_pulse && (cpha ? !lead : lead);
    shift_now  = edge_pulse && (cpha ? (lead && (cnt_q != '0)) : !lead);

    sr_d  = sr_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    act_d = act_q;

    if (sample_now && cpha && last) begin
      sr_d = push(sr_q, sdi, lsb_first);
    end else begin
      if (sample_now) rx_d = sdi;
      if (shift_now)  sr_d = push(sr_q, rx_q, lsb_first);
    end

    if (edge_pulse) begin
      if (last) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    if (load) begin
      sr_d  = ldata;
      act_d = go;
    end

    if (abort) begin
      cnt_d = '0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      rx_q  <= 1'b0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign done = edge_pulse && last && !abort;
  assign word = sr_d;
  assign sdo  = lsb_first ? sr_q[0] : sr_q[W-1];
  assign busy = act_q || (cnt_q != '0);

  assert_done_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));

  assert_go_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && go && !abort) |=> busy);

endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned DIV_CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_gate,
  input  logic       irq_ack,
  output logic       irq,
  input  logic       sel_n,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_drive,
  input  logic       sdi,
  output logic       sdo
);
  import spi_port_pkg::*;

  localparam int unsigned BYTE_W = 8;

  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // pin synchronizers: bit 1 select (idle high), bit 0 serial clock
  logic [1:0] pins_s;
  logic       sel_s, sclk_s;

  spi_port_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     ({sel_n, sclk_in}),
    .q     (pins_s)
  );
  assign sel_s  = pins_s[1];
  assign sclk_s = pins_s[0];

  // state
  ctrl_t            ctrl_q, ctrl_d;
  logic             dbl_q, dbl_d;
  logic             flag_q, flag_d;
  logic             wcol_q, wcol_d;
  logic             armed_q, armed_d;
  logic             sclk_prev_q;
  logic [BYTE_W-1:0] rx_q, rx_d;

  // decode and control
  logic ctrl_wr, stat_wr, stat_rd, dat_wr, dat_rd, dat_any;
  logic master_en, slave_en, fault, clr_seq;
  logic load, go, abort, busy, done, tick, lvl, slv_edge, edge_pulse;
  logic [BYTE_W-1:0]    rx_word;
  logic [DIV_CNT_W-1:0] half_m1;

  always_comb begin
    ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
    stat_wr = reg_wr && (reg_addr == REG_STAT);
    stat_rd = reg_rd && (reg_addr == REG_STAT);
    dat_wr  = reg_wr && (reg_addr == REG_DATA);
    dat_rd  = reg_rd && (reg_addr == REG_DATA);
    dat_any = dat_wr || dat_rd;

    master_en = ctrl_q.en && ctrl_q.master;
    slave_en  = ctrl_q.en && !ctrl_q.master;
    fault     = master_en && !sel_s;

    slv_edge   = slave_en && !sel_s && (sclk_s != sclk_prev_q);
    edge_pulse = master_en ? tick : slv_edge;

    load  = dat_wr && !busy;
    go    = master_en && !fault;
    abort = !ctrl_q.en || fault || (slave_en && sel_s);

    clr_seq = armed_q && dat_any;
    half_m1 = DIV_CNT_W'(half_minus_one(ctrl_q.rate, dbl_q));
  end

  // next state
  always_comb begin
    ctrl_d  = ctrl_q;
    dbl_d   = dbl_q;
    flag_d  = flag_q;
    wcol_d  = wcol_q;
    armed_d = armed_q;
    rx_d    = rx_q;

    if (ctrl_wr) ctrl_d = ctrl_t'(reg_wdata);
    if (fault)   ctrl_d.master = 1'b0;

    if (stat_wr) dbl_d = reg_wdata[0];

    if (clr_seq || irq_ack) flag_d = 1'b0;
    if (done || fault)      flag_d = 1'b1;

    if (clr_seq)           wcol_d = 1'b0;
    if (dat_wr && busy)    wcol_d = 1'b1;

    if (dat_any)           armed_d = 1'b0;
    if (stat_rd && flag_q) armed_d = 1'b1;

    if (done) rx_d = rx_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      dbl_q       <= 1'b0;
      flag_q      <= 1'b0;
      wcol_q      <= 1'b0;
      armed_q     <= 1'b0;
      rx_q        <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      dbl_q       <= dbl_d;
      flag_q      <= flag_d;
      wcol_q      <= wcol_d;
      armed_q     <= armed_d;
      rx_q        <= rx_d;
      sclk_prev_q <= sclk_s;
    end
  end

  spi_port_clkgen #(.CNT_W(DIV_CNT_W)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (master_en && busy),
    .half_m1 (half_m1),
    .tick    (tick),
    .lvl     (lvl)
  );

  spi_port_shifter #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load       (load),
    .go         (go),
    .abort      (abort),
    .edge_pulse (edge_pulse),
    .lsb_first  (ctrl_q.lsb),
    .cpha       (ctrl_q.pha),
    .sdi        (sdi),
    .ldata      (reg_wdata),
    .sdo        (sdo),
    .busy       (busy),
    .done       (done),
    .word       (rx_word)
  );

  // outputs
  always_comb begin
    case (reg_sel_e'(reg_addr))
      REG_CTRL: reg_rdata = ctrl_q;
      REG_STAT: reg_rdata = {flag_q, wcol_q, 5'b00000, dbl_q};
      REG_DATA: reg_rdata = rx_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq        = flag_q && ctrl_q.irq_en && irq_gate;
  assign sclk_out   = ctrl_q.pol ^ lvl;
  assign sclk_drive = master_en;

  // checks beside the logic they guard
  assert_fault_drops_master_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    fault |=> (!ctrl_q.master && flag_q));

  assert_busy_write_collides_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_wr && busy) |=> wcol_q);

  assert_done_raises_flag_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> flag_q);

  assert_sck_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_en && !busy) |-> (sclk_out == ctrl_q.pol));

  assert_ack_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_ack && !done && !fault) |=> !flag_q);

endmodule

// File: tb/spi_port_test.sv
module spi_port_test;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_gate, irq_ack, irq;
  logic       sel_n, sclk_in, sclk_out, sclk_drive, sdi, sdo;
  logic       slave_mode, tb_sdi;

  int n_run  = 0;
  int n_fail = 0;

  assign sdi = slave_mode ? tb_sdi : sdo;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_gate(irq_gate), .irq_ack(irq_ack),
    .irq(irq), .sel_n(sel_n), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_drive(sclk_drive), .sdi(sdi), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // wire monitor: bit on the line just before each capture-type edge
  logic       mon_en, cfg_pol, cfg_pha, sck_last, sdo_last;
  int         toggles, nbits;
  logic [7:0] wire_byte;

  always @(negedge clk) begin
    if (mon_en && (sclk_out != sck_last)) begin
      toggles = toggles + 1;
      if (cfg_pha ? (sck_last != cfg_pol) : (sck_last == cfg_pol)) begin
        wire_byte = {wire_byte[6:0], sdo_last};
        nbits     = nbits + 1;
      end
    end
    sck_last = sclk_out;
    sdo_last = sdo;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int ratio_of(input logic [1:0] rate, input logic dbl);
    int base;
    base = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    return dbl ? base / 2 : base;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  task automatic master_xfer(input logic [7:0] d, input logic lsb, input logic pol,
                             input logic pha, input logic [1:0] rate, input logic dbl);
    int         r;
    logic [7:0] st, got, expw;
    r = ratio_of(rate, dbl);
    wr(2'd0, {1'b0, rate, pha, pol, lsb, 1'b1, 1'b1});
    wr(2'd1, {7'b0, dbl});
    chk(sclk_out == pol && sclk_drive, "R3 idle before", sclk_out, pol);
    cfg_pol = pol; cfg_pha = pha; toggles = 0; nbits = 0; wire_byte = '0; mon_en = 1'b1;
    wr(2'd2, d);
    repeat (8 * r - 1) @(posedge clk);
    #1 peek(2'd1, st);
    chk(st[7] == 1'b0, "R5 flag early", st[7], 0);
    @(posedge clk);
    #1 peek(2'd1, st);
    chk(st[7] == 1'b1, "R5 flag on time", st[7], 1);
    @(negedge clk); @(negedge clk);
    mon_en = 1'b0;
    chk(toggles == 16, "R4 edge count", toggles, 16);
    expw = lsb ? rev8(d) : d;
    chk(nbits == 8 && wire_byte == expw, "R2 R4 wire order", wire_byte, expw);
    chk(sclk_out == pol, "R3 idle after", sclk_out, pol);
    rd(2'd1, st);
    rd(2'd2, got);
    chk(got == d, "R6 loopback", got, d);
    peek(2'd1, st);
    chk(st[7] == 1'b0, "R8 flag cleared", st[7], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, got, so;
    logic [7:0] bytes [2];
    bytes[0] = 8'hA5; bytes[1] = 8'h3C;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    irq_gate = 1'b0; irq_ack = 1'b0; sel_n = 1'b1; sclk_in = 1'b0;
    slave_mode = 1'b0; tb_sdi = 1'b0; mon_en = 1'b0;
    cfg_pol = 1'b0; cfg_pha = 1'b0; toggles = 0; nbits = 0; wire_byte = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    peek(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    peek(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
    peek(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);
    chk(irq == 1'b0 && sclk_drive == 1'b0, "R1 outputs", {irq, sclk_drive}, 0);

    // R12 status layout
    wr(2'd1, 8'hFF); peek(2'd1, v); chk(v == 8'h01, "R12 only bit0", v, 8'h01);
    wr(2'd1, 8'h00); peek(2'd1, v); chk(v == 8'h00, "R12 clear bit0", v, 0);

    // all phases, polarities and orders at the fastest ratio
    for (int m = 0; m < 8; m++)
      for (int b = 0; b < 2; b++)
        master_xfer(bytes[b], m[0], m[1], m[2], 2'd0, 1'b1);

    // every ratio
    for (int k = 0; k < 8; k++)
      master_xfer(8'h5A ^ 8'(k), 1'b0, 1'b0, 1'b0, k[1:0], k[2]);

    // R7 / R9 interrupt request and acknowledge
    wr(2'd0, 8'h83); wr(2'd1, 8'h01);
    irq_gate = 1'b1;
    wr(2'd2, 8'h11);
    chk(irq == 1'b0, "R7 no irq while busy", irq, 0);
    repeat (20) @(posedge clk);
    #1 chk(irq == 1'b1, "R7 irq raised", irq, 1);
    irq_gate = 1'b0;
    #1 chk(irq == 1'b0, "R7 gate low", irq, 0);
    irq_gate = 1'b1;
    @(negedge clk) irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    peek(2'd1, v);
    chk(v[7] == 1'b0 && irq == 1'b0, "R9 ack clears", {v[7], irq}, 0);

    // R10 write collision
    wr(2'd0, 8'h03); wr(2'd1, 8'h01);
    wr(2'd2, 8'h96);
    repeat (3) @(posedge clk);
    wr(2'd2, 8'hFF);
    peek(2'd1, v); chk(v[6] == 1'b1, "R10 wcol set", v[6], 1);
    repeat (30) @(posedge clk);
    rd(2'd1, v);
    chk(v == 8'hC1, "R10 status both flags", v, 8'hC1);
    rd(2'd2, got);
    chk(got == 8'h96, "R10 write ignored", got, 8'h96);
    peek(2'd1, v); chk(v == 8'h01, "R8 R10 flags cleared", v, 8'h01);

    // R8 data access without a prior status read leaves the flag
    wr(2'd2, 8'h22);
    repeat (30) @(posedge clk);
    rd(2'd2, got);
    peek(2'd1, v); chk(v[7] == 1'b1, "R8 needs status read", v[7], 1);
    rd(2'd1, v); wr(2'd2, 8'h00);
    peek(2'd1, v); chk(v[7] == 1'b0, "R8 write clears", v[7], 0);
    repeat (30) @(posedge clk);
    rd(2'd1, v); rd(2'd2, got);

    // R11 mode fault
    wr(2'd0, 8'h03);
    @(negedge clk) sel_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 peek(2'd0, v); chk(v[1] == 1'b1, "R11 not yet", v[1], 1);
    @(posedge clk);
    #1 peek(2'd0, v); chk(v[1] == 1'b0, "R11 master cleared", v[1], 0);
    peek(2'd1, v); chk(v[7] == 1'b1 && sclk_drive == 1'b0, "R11 flag and release", {v[7], sclk_drive}, 2);
    @(negedge clk) sel_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 peek(2'd0, v); chk(v[1] == 1'b0, "R11 stays slave", v[1], 0);
    @(negedge clk) irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;

    // R13 slave transfer, phase 0, MSB first, rate bits set
    wr(2'd0, 8'h61);
    slave_mode = 1'b1;
    wr(2'd2, 8'h3C);
    @(negedge clk) sel_n = 1'b0;
    repeat (6) @(negedge clk);
    so = '0;
    for (int i = 7; i >= 0; i--) begin
      tb_sdi = bytes[0][i];
      repeat (8) @(negedge clk);
      so = {so[6:0], sdo};
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (10) @(negedge clk);
    peek(2'd1, v); chk(v[7] == 1'b1, "R13 slave flag", v[7], 1);
    chk(so == 8'h3C, "R13 slave out", so, 8'h3C);
    rd(2'd1, v); rd(2'd2, got);
    chk(got == 8'hA5, "R13 slave in", got, 8'hA5);
    @(negedge clk) sel_n = 1'b1;
    slave_mode = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule